// File: doc/BRIEF.md
# Dual dead-band pair generator with logic combiner

This block takes one raw PWM channel from each of two waveform generators and turns each into an active-high complementary pair with dead time. In each pair, the high-side output follows the raw signal, but its rising edge is delayed by a programmable count. The low-side output follows the inverted raw signal, but its rising edge, which occurs when the raw signal falls, is delayed by a separate count. The two pairs are then merged into two pin-level outputs. The first output is the exclusive-OR of the two high-side signals. The second output is the exclusive-NOR of the two low-side signals.

Each delay is counted in clock cycles by a run-length counter. The counter restarts whenever the raw input changes. An edge appears at the output only when the raw level has stayed put for longer than the programmed delay, so a pulse shorter than the delay produces no pulse at all. Every pair output is registered. The two merged outputs are formed from those registers, so all six outputs share the same latency. The asynchronous active-low reset is released synchronously inside the block.

Top module: `pwm_pair_mixer`

## Requirements
- R1: The high side of a pair rises at the first clock edge on which the raw input has been sampled high on rise_dly+1 consecutive edges. It is low after any edge that samples the raw input low.
- R2: The low side of a pair rises at the first clock edge on which the raw input has been sampled low on fall_dly+1 consecutive edges. It is low after any edge that samples the raw input high.
- R3: The high and low sides of a pair are never high on the same cycle.
- R4: mix_a equals gen1_hi XOR gen2_hi on every cycle.
- R5: mix_b equals NOT (gen1_lo XOR gen2_lo) on every cycle, so it is high while both low sides are low, including just after reset.
- R6: A raw high (or low) level that lasts no more than rise_dly (or fall_dly) samples produces no pulse on the high (or low) side.
- R7: The delay count restarts on every raw-input change, so two short pulses separated by a short gap do not add up to reach the delay.
- R8: With a delay of 0, the delayed edge appears one clock after the sampling edge, the same latency as the undelayed edge.
- R9: After reset, both sides of a pair stay low until the raw input of that pair first changes level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen1_raw | input | 1 | Raw PWM from generator 1 |
| gen2_raw | input | 1 | Raw PWM from generator 2 |
| gen1_rise_dly | input | DLY_W | Rising-edge delay for pair 1, in clocks |
| gen1_fall_dly | input | DLY_W | Falling-edge delay for pair 1, in clocks |
| gen2_rise_dly | input | DLY_W | Rising-edge delay for pair 2, in clocks |
| gen2_fall_dly | input | DLY_W | Falling-edge delay for pair 2, in clocks |
| gen1_hi | output | 1 | High side of pair 1 |
| gen1_lo | output | 1 | Low side of pair 1 |
| gen2_hi | output | 1 | High side of pair 2 |
| gen2_lo | output | 1 | Low side of pair 2 |
| mix_a | output | 1 | XOR of the two high sides |
| mix_b | output | 1 | XNOR of the two low sides |

## Verification
The bench first applies two phase-shifted square waves with long levels and a delay of 20. This pattern separates the rising-edge delay from the falling-edge delay and shows that the XOR and XNOR merges follow the pairs as they overlap. Pulses shorter than the delay, and pairs of short pulses split by a brief gap, then show whether a counter cancels an edge or wrongly accumulates time across a raw-input change. A run with all delays at 0 and single-cycle toggles exposes any extra latency on the delayed path. A pseudo-random run with unequal delays on the two edges catches swapped or shared delay registers.

// File: rtl/pwm_mix_pkg.sv
package pwm_mix_pkg;
  // default width of the delay registers
  localparam int unsigned DLY_W_DEF = 8;
  // number of generator channels merged by the block
  localparam int unsigned NUM_GEN   = 2;
endpackage

// File: rtl/dbm_rst_sync.sv
module dbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/dbm_run_counter.sv
module dbm_run_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] run_nxt,
  output logic [CW-1:0] run_q
);
  localparam logic [CW-1:0] RUN_SAT = {CW{1'b1}};
  localparam logic [CW-1:0] RUN_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic run_en;

  always_comb begin
    run_en  = restart || (run_q != RUN_SAT);
    run_nxt = run_q;
    if (restart)     run_nxt = RUN_ONE;
    else if (run_en) run_nxt = run_q + RUN_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_nxt;
  end
endmodule

// File: rtl/dbm_pair_gen.sv
module dbm_pair_gen #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             hi,
  output logic             lo
);
  localparam int unsigned CW = DLY_W + 1;

  logic          raw_q, seen_q, hi_q, lo_q;
  logic          chg, seen_nxt, hi_nxt, lo_nxt;
  logic [CW-1:0] run_nxt, run_q;

  dbm_run_counter #(.CW(CW)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (chg),
    .run_nxt (run_nxt),
    .run_q   (run_q)
  );

  always_comb begin
    chg      = raw ^ raw_q;
    seen_nxt = seen_q | chg;
    hi_nxt   = seen_nxt &  raw & (run_nxt > {1'b0, rise_dly});
    lo_nxt   = seen_nxt & ~raw & (run_nxt > {1'b0, fall_dly});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      seen_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      raw_q  <= raw;
      seen_q <= seen_nxt;
      hi_q   <= hi_nxt;
      lo_q   <= lo_nxt;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(hi && lo)); // R3
  AST_HI_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n) hi |-> raw_q); // R1
  AST_LO_NEEDS_NOT_RAW: assert property (@(posedge clk) disable iff (!rst_n) lo |-> !raw_q); // R2
  AST_QUIET_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !seen_q |-> (!hi && !lo)); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (raw != raw_q) |=> (run_q == {{(CW-1){1'b0}}, 1'b1})); // R7
endmodule

// File: rtl/pwm_pair_mixer.sv
module pwm_pair_mixer
  import pwm_mix_pkg::*;
#(
  parameter int unsigned DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen1_raw,
  input  logic             gen2_raw,
  input  logic [DLY_W-1:0] gen1_rise_dly,
  input  logic [DLY_W-1:0] gen1_fall_dly,
  input  logic [DLY_W-1:0] gen2_rise_dly,
  input  logic [DLY_W-1:0] gen2_fall_dly,
  output logic             gen1_hi,
  output logic             gen1_lo,
  output logic             gen2_hi,
  output logic             gen2_lo,
  output logic             mix_a,
  output logic             mix_b
);
  logic                   rst_n_i;
  logic [NUM_GEN-1:0]     raw_v, hi_v, lo_v;
  logic [DLY_W-1:0]       rise_v [NUM_GEN];
  logic [DLY_W-1:0]       fall_v [NUM_GEN];

  dbm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign raw_v     = {gen2_raw, gen1_raw};
  assign rise_v[0] = gen1_rise_dly;
  assign rise_v[1] = gen2_rise_dly;
  assign fall_v[0] = gen1_fall_dly;
  assign fall_v[1] = gen2_fall_dly;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_pair
    dbm_pair_gen #(.DLY_W(DLY_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .raw      (raw_v[g]),
      .rise_dly (rise_v[g]),
      .fall_dly (fall_v[g]),
      .hi       (hi_v[g]),
      .lo       (lo_v[g])
    );
  end

  assign gen1_hi = hi_v[0];
  assign gen1_lo = lo_v[0];
  assign gen2_hi = hi_v[1];
  assign gen2_lo = lo_v[1];
  assign mix_a   = ^hi_v;
  assign mix_b   = ~(^lo_v);

  AST_MIX_A_STEADY: assert property (@(posedge clk) disable iff (!rst_n_i) ($stable(gen1_hi) && $stable(gen2_hi)) |-> $stable(mix_a)); // R4
  AST_MIX_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i) (!gen1_lo && !gen2_lo) |-> mix_b); // R5
endmodule

// File: tb/pwm_pair_mixer_tb_top.sv
module pwm_pair_mixer_tb_top;
  localparam int unsigned DW = 8;
  localparam time CLK_P = 5ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          gen1_raw, gen2_raw;
  logic [DW-1:0] r1, f1, r2, f2;
  logic          gen1_hi, gen1_lo, gen2_hi, gen2_lo, mix_a, mix_b;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "reset";

  // reference state per generator
  int m_run  [2];
  bit m_prev [2];
  bit m_seen [2];
  bit m_hi   [2];
  bit m_lo   [2];

  always #(CLK_P/2) clk = ~clk;

  pwm_pair_mixer #(.DLY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen1_raw(gen1_raw), .gen2_raw(gen2_raw),
    .gen1_rise_dly(r1), .gen1_fall_dly(f1), .gen2_rise_dly(r2), .gen2_fall_dly(f2),
    .gen1_hi(gen1_hi), .gen1_lo(gen1_lo), .gen2_hi(gen2_hi), .gen2_lo(gen2_lo),
    .mix_a(mix_a), .mix_b(mix_b)
  );

  task automatic check(input bit act, input bit exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s (%s): actual %0b expected %0b at %0t", req, what, phase, act, exp, $time);
    end
  endtask

  // behavioural reference: run length of the current raw level
  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      bit raw;
      int rd, fd;
      raw = (g == 0) ? gen1_raw : gen2_raw;
      rd  = (g == 0) ? int'(r1) : int'(r2);
      fd  = (g == 0) ? int'(f1) : int'(f2);
      if (!rst_n) begin
        m_run[g] = 0; m_prev[g] = 0; m_seen[g] = 0; m_hi[g] = 0; m_lo[g] = 0;
      end else begin
        if (raw != m_prev[g]) begin
          m_run[g] = 1; m_seen[g] = 1;
        end else if (m_run[g] < 100000) begin
          m_run[g]++;
        end
        m_hi[g]   = m_seen[g] &&  raw && (m_run[g] > rd);
        m_lo[g]   = m_seen[g] && !raw && (m_run[g] > fd);
        m_prev[g] = raw;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(gen1_hi, m_hi[0], "R1", "gen1_hi");
      check(gen2_hi, m_hi[1], "R1", "gen2_hi");
      check(gen1_lo, m_lo[0], "R2", "gen1_lo");
      check(gen2_lo, m_lo[1], "R2", "gen2_lo");
      check(gen1_hi && gen1_lo, 1'b0, "R3", "pair1 overlap");
      check(gen2_hi && gen2_lo, 1'b0, "R3", "pair2 overlap");
      check(mix_a, m_hi[0] ^ m_hi[1], "R4", "mix_a");
      check(mix_b, !(m_lo[0] ^ m_lo[1]), "R5", "mix_b");
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; gen1_raw = 1'b0; gen2_raw = 1'b0;
    r1 = 8'd20; f1 = 8'd20; r2 = 8'd20; f2 = 8'd20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R9 and R5: quiet after reset
    check(gen1_hi, 1'b0, "R9", "gen1_hi after reset");
    check(gen1_lo, 1'b0, "R9", "gen1_lo after reset");
    check(gen2_hi, 1'b0, "R9", "gen2_hi after reset");
    check(gen2_lo, 1'b0, "R9", "gen2_lo after reset");
    check(mix_b, 1'b1, "R5", "mix_b idle high");

    // phase-shifted square waves, delay 20
    phase = "square";
    for (int c = 0; c < 360; c++) begin
      gen1_raw = ((c / 40) % 2) == 0;
      gen2_raw = (((c + 13) / 40) % 2) == 0;
      @(negedge clk);
    end

    // R6: short pulses never reach delay 20
    phase = "short";
    gen1_raw = 1'b0; gen2_raw = 1'b1;
    repeat (30) @(negedge clk);
    for (int c = 0; c < 200; c++) begin
      gen1_raw = (c % 40) < 6;
      gen2_raw = (c % 40) >= 8;
      @(negedge clk);
      if (c >= 30) check(gen1_hi, 1'b0, "R6", "short high pulse cancelled");
    end

    // R7: pulse, short gap, pulse: counts must not accumulate
    phase = "restart";
    gen1_raw = 1'b0;
    repeat (30) @(negedge clk);
    for (int c = 0; c < 32; c++) begin
      gen1_raw = (c < 15) || (c >= 17);
      @(negedge clk);
      check(gen1_hi, 1'b0, "R7", "no carry across restart");
    end
    gen1_raw = 1'b0;
    repeat (30) @(negedge clk);

    // R8: zero delay gives one clock of latency
    phase = "zero";
    r1 = '0; f1 = '0; r2 = '0; f2 = '0;
    @(negedge clk);
    gen1_raw = 1'b1;
    @(negedge clk);
    check(gen1_hi, 1'b1, "R8", "zero-delay rise latency");
    gen1_raw = 1'b0;
    @(negedge clk);
    check(gen1_lo, 1'b1, "R8", "zero-delay fall latency");
    for (int c = 0; c < 100; c++) begin
      gen1_raw = c[0];
      gen2_raw = c[1];
      @(negedge clk);
    end

    // unequal delays with pseudo-random inputs
    phase = "random";
    r1 = 8'd3; f1 = 8'd9; r2 = 8'd7; f2 = 8'd2;
    lfsr = 8'hA5;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0] && lfsr[3]) gen1_raw = ~gen1_raw;
      if (lfsr[2] && lfsr[6]) gen2_raw = ~gen2_raw;
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule